// File: doc/BRIEF.md
# Trimmed-Mean Sample Averager

This block gathers a burst of N conversion results from an analog-to-digital converter and reduces them to one averaged 12-bit code. For every sample it raises a one-cycle conversion request, waits for the converter's end-of-conversion strobe, and stores the returned code in a local buffer of up to eight entries.

When a nonzero discard count X is given, the buffer is first put into ascending order with an adjacent compare-and-swap sort. The sort stops after the first pass that makes no exchange. X/2 entries are then dropped from each end. The kept entries are summed and divided by N-X. A divisor that is a power of two is applied as a right shift, and any other divisor goes through a short sequential divider. With X equal to zero the sort is skipped and the result is the plain mean.

A start/busy/done handshake launches the burst and returns the result. Typical settings are 4, 6 or 8 samples with nothing dropped, and 8 samples with 4 dropped.

Top module: `tmavg_top`

## Requirements
- R1: Each sample is requested by a single-cycle `soc_o` pulse. No further pulse follows until an `eoc_i` strobe has been accepted, and the code on `adc_data_i` is captured on that strobe. Exactly N pulses are issued per burst. An `eoc_i` strobe that arrives while no request is outstanding is ignored.
- R2: Samples are 12-bit unsigned codes, and up to 8 are held. Eight full-scale samples (4095) average to 4095, with no overflow.
- R3: With X = 0, `avg_o` equals the sum of all N samples divided by N, truncated.
- R4: With X > 0, the samples are sorted in ascending order. Entries X/2 through N-X/2-1 are summed and divided by N-X, truncated. The result does not depend on the order in which the samples arrived.
- R5: A divisor that is not a power of two (6) yields the exact truncated quotient.
- R6: A start with N = 0, N > 8, odd N, odd X, or X >= N is rejected. On the cycle after start, `done_o` and `err_o` are high and `avg_o` is 0, and no `soc_o` is ever issued for it.
- R7: `busy_o` is high from the cycle after an accepted start through the cycle of `done_o`. `done_o` is a single-cycle pulse.
- R8: `avg_o` and `err_o` hold their values until the next start. A `start_i` received while busy is ignored, and the running burst keeps its latched N and X.
- R9: After reset, `busy_o`, `done_o`, `soc_o` and `err_o` are low and `avg_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a burst (sampled while idle) |
| cnt_i | input | 4 | Number of samples N |
| drop_i | input | 4 | Number of samples discarded X |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | Single-cycle completion pulse |
| err_o | output | 1 | Last start had an invalid configuration |
| avg_o | output | 12 | Averaged result |
| soc_o | output | 1 | Start-of-conversion request pulse |
| eoc_i | input | 1 | End-of-conversion strobe |
| adc_data_i | input | 12 | Conversion result, valid with eoc_i |

## Verification
A corrupted sort or a wrong trim window leaves the request handshake intact. It shows only in the value of `avg_o` at the `done_o` pulse, so every burst is checked against a mean computed independently in the bench, and the inputs are fed out of order so that an unsorted buffer gives a different answer. A fault in the divider also appears in that same final value, but only for six kept samples. A sequencing fault shows at once at the ports: a missing or extra `soc_o`, a capture taken on a stray strobe, or a `busy_o`/`done_o` edge in the wrong cycle.

// File: rtl/tmavg_pkg.sv
package tmavg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_WAIT, ST_SORT, ST_SUM, ST_DIV, ST_DIVW, ST_DONE
  } state_t;

  function automatic int unsigned flog2(input int unsigned v);
    int unsigned r;
    r = 0;
    for (int i = 1; i < 32; i++) if ((v >> i) != 0) r = i;
    return r;
  endfunction
endpackage

// File: rtl/tmavg_sorter.sv
module tmavg_sorter #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 12,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              go_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              fin_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  j_q;
  logic              active_q, swp_q;
  logic              do_swap, last_cmp;

  assign do_swap   = active_q && (mem[j_q] > mem[j_q + IDX_W'(1)]);
  assign last_cmp  = (CNT_W'(j_q) == len_i - CNT_W'(2));
  assign rd_data_o = mem[rd_idx_i];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      mem[wr_idx_i] <= wr_data_i;
    end else if (do_swap) begin
      mem[j_q]              <= mem[j_q + IDX_W'(1)];
      mem[j_q + IDX_W'(1)]  <= mem[j_q];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      swp_q    <= 1'b0;
      j_q      <= '0;
      fin_o    <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (go_i) begin
        active_q <= 1'b1;
        swp_q    <= 1'b0;
        j_q      <= '0;
      end else if (active_q) begin
        if (last_cmp) begin
          j_q   <= '0;
          swp_q <= 1'b0;
          if (!(swp_q || do_swap)) begin
            active_q <= 1'b0;
            fin_o    <= 1'b1;
          end
        end else begin
          j_q   <= j_q + IDX_W'(1);
          swp_q <= swp_q | do_swap;
        end
      end
    end
  end
endmodule

// File: rtl/tmavg_div.sv
module tmavg_div #(
  parameter int NUM_W = 15,
  parameter int DEN_W = 4,
  localparam int CW   = $clog2(NUM_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             fin_o
);
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W:0]   trial;
  logic [CW-1:0]    cnt_q;
  logic             run_q;

  assign trial = {rem_q, quo_o[NUM_W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_o <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_o <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (go_i) begin
        quo_o <= num_i;
        rem_q <= '0;
        cnt_q <= CW'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (trial >= {1'b0, den_i}) begin
          rem_q <= DEN_W'(trial - {1'b0, den_i});
          quo_o <= {quo_o[NUM_W-2:0], 1'b1};
        end else begin
          rem_q <= trial[DEN_W-1:0];
          quo_o <= {quo_o[NUM_W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmavg_top.sv
module tmavg_top #(
  parameter int DATA_W = 12,
  parameter int MAX_N  = 8,
  localparam int IDX_W = $clog2(MAX_N),
  localparam int CNT_W = $clog2(MAX_N + 1),
  localparam int ACC_W = DATA_W + $clog2(MAX_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  drop_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] avg_o,
  output logic              soc_o,
  input  logic              eoc_i,
  input  logic [DATA_W-1:0] adc_data_i
);
  import tmavg_pkg::*;

  state_t            st_q;
  logic [CNT_W-1:0]  n_q, x_q;
  logic [IDX_W-1:0]  idx_q, sidx_q;
  logic [ACC_W-1:0]  acc_q;
  logic [DATA_W-1:0] rd_data;
  logic [ACC_W-1:0]  quo;
  logic              sort_go, sort_fin, div_go, div_fin, cfg_ok, wr_en, pow2;
  logic [CNT_W-1:0]  lo, hi, keep;

  assign cfg_ok = (cnt_i >= CNT_W'(2)) && (cnt_i <= CNT_W'(MAX_N)) && !cnt_i[0]
                  && !drop_i[0] && (drop_i < cnt_i);
  assign lo      = x_q >> 1;
  assign hi      = n_q - lo - CNT_W'(1);
  assign keep    = n_q - x_q;
  assign pow2    = ((keep & (keep - CNT_W'(1))) == '0);
  assign wr_en   = (st_q == ST_WAIT) && eoc_i;
  assign sort_go = wr_en && (CNT_W'(idx_q) == n_q - CNT_W'(1)) && (x_q != '0);
  assign div_go  = (st_q == ST_DIV) && !pow2;

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_DONE);
  assign soc_o  = (st_q == ST_REQ);

  tmavg_sorter #(.DEPTH(MAX_N), .DATA_W(DATA_W)) u_sort (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(idx_q), .wr_data_i(adc_data_i),
    .go_i(sort_go), .len_i(n_q), .rd_idx_i(sidx_q), .rd_data_o(rd_data),
    .fin_o(sort_fin)
  );

  tmavg_div #(.NUM_W(ACC_W), .DEN_W(CNT_W)) u_div (
    .clk_i, .rst_ni, .go_i(div_go), .num_i(acc_q), .den_i(keep),
    .quo_o(quo), .fin_o(div_fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      n_q    <= '0;
      x_q    <= '0;
      idx_q  <= '0;
      sidx_q <= '0;
      acc_q  <= '0;
      avg_o  <= '0;
      err_o  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (cfg_ok) begin
            n_q   <= cnt_i;
            x_q   <= drop_i;
            idx_q <= '0;
            err_o <= 1'b0;
            st_q  <= ST_REQ;
          end else begin
            err_o <= 1'b1;
            avg_o <= '0;
            st_q  <= ST_DONE;
          end
        end
        ST_REQ: st_q <= ST_WAIT;
        ST_WAIT: if (eoc_i) begin
          if (CNT_W'(idx_q) == n_q - CNT_W'(1)) begin
            acc_q  <= '0;
            sidx_q <= IDX_W'(lo);
            st_q   <= (x_q == '0) ? ST_SUM : ST_SORT;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
            st_q  <= ST_REQ;
          end
        end
        ST_SORT: if (sort_fin) st_q <= ST_SUM;
        ST_SUM: begin
          acc_q <= acc_q + ACC_W'(rd_data);
          if (CNT_W'(sidx_q) == hi) st_q <= ST_DIV;
          else sidx_q <= sidx_q + IDX_W'(1);
        end
        ST_DIV: begin
          if (pow2) begin
            avg_o <= DATA_W'(acc_q >> flog2(int'(keep)));
            st_q  <= ST_DONE;
          end else begin
            st_q <= ST_DIVW;
          end
        end
        ST_DIVW: if (div_fin) begin
          avg_o <= DATA_W'(quo);
          st_q  <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tmavg_checker.sv
module tmavg_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              soc_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [DATA_W-1:0] avg_o
);
  assert_soc_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_o |=> !soc_o);
  assert_soc_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_o |-> busy_o);
  assert_no_soc_on_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_o |-> !err_o);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(avg_o) && $stable(err_o)));
endmodule

bind tmavg_top tmavg_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .soc_o(soc_o),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .avg_o(avg_o)
);

// File: tb/tmavg_top_tb.sv
`timescale 1ns/1ps
module tmavg_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  cnt_i = '0;
  logic [3:0]  drop_i = '0;
  logic        busy_o, done_o, err_o, soc_o;
  logic [11:0] avg_o;
  logic        eoc_i = 1'b0;
  logic [11:0] adc_data_i = '0;

  int total = 0;
  int bad = 0;
  logic [11:0] smp [8];

  always #2 clk_i = ~clk_i;

  tmavg_top u_dut (
    .clk_i, .rst_ni, .start_i, .cnt_i, .drop_i, .busy_o, .done_o, .err_o,
    .avg_o, .soc_o, .eoc_i, .adc_data_i
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_avg(input int n, input int x);
    int t [8];
    int s, tmp;
    for (int i = 0; i < n; i++) t[i] = smp[i];
    for (int a = 0; a < n; a++)
      for (int b = 0; b < n - 1; b++)
        if (t[b] > t[b+1]) begin tmp = t[b]; t[b] = t[b+1]; t[b+1] = tmp; end
    s = 0;
    for (int i = x / 2; i < n - x / 2; i++) s += t[i];
    return s / (n - x);
  endfunction

  // poke: raise start_i with another config while the burst runs
  task automatic run_case(input int n, input int x, input string req, input bit poke);
    int exp, guard, socs_extra;
    bit busy_ok;
    exp = expect_avg(n, x);
    socs_extra = 0;
    busy_ok = 1;
    @(negedge clk_i);
    cnt_i = 4'(n); drop_i = 4'(x); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      guard = 0;
      while (!soc_o && guard < 50) begin @(negedge clk_i); guard++; end
      chk(soc_o, "R1 request issued", k, n);
      if (poke && k == 1) begin cnt_i = 4'd2; drop_i = 4'd0; start_i = 1'b1; end
      for (int l = 0; l < 1 + (k % 3); l++) begin
        @(negedge clk_i);
        start_i = 1'b0;
        if (soc_o) socs_extra++;
      end
      eoc_i = 1'b1; adc_data_i = smp[k];
      @(negedge clk_i);
      eoc_i = 1'b0; adc_data_i = 12'hABC;
    end
    chk(socs_extra == 0, "R1 no request before eoc", socs_extra, 0);
    guard = 0;
    while (!done_o && guard < 500) begin
      if (!busy_o) busy_ok = 0;
      if (soc_o) socs_extra++;
      @(negedge clk_i); guard++;
    end
    chk(busy_ok, "R7 busy during burst", 0, 1);
    chk(socs_extra == 0, "R1 exactly N requests", socs_extra, 0);
    chk(done_o && busy_o, "R7 done with busy", done_o, 1);
    chk(avg_o == 12'(exp), req, avg_o, exp);
    chk(!err_o, "R6 no error on valid cfg", err_o, 0);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R7 done single pulse", done_o, 0);
    repeat (3) @(negedge clk_i);
    chk(avg_o == 12'(exp), "R8 result held", avg_o, exp);
  endtask

  task automatic run_bad(input int n, input int x);
    @(negedge clk_i);
    cnt_i = 4'(n); drop_i = 4'(x); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o && err_o && !soc_o, "R6 immediate error done", {done_o, err_o, soc_o}, 6);
    chk(avg_o == 12'd0, "R6 result zero on error", avg_o, 0);
    @(negedge clk_i);
    chk(!busy_o && !done_o && !soc_o, "R6 idle after error", busy_o, 0);
    repeat (2) @(negedge clk_i);
    chk(err_o && !soc_o, "R8 error held", err_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !soc_o && !err_o && avg_o == 0, "R9 reset state", avg_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !soc_o, "R9 idle after reset", busy_o, 0);

    // R3 plain mean, N=4
    smp[0] = 100; smp[1] = 200; smp[2] = 301; smp[3] = 402;
    run_case(4, 0, "R3 mean of 4", 0);
    // R1: stray eoc while idle is ignored, then repeat same burst
    @(negedge clk_i); eoc_i = 1'b1; adc_data_i = 12'hFFF;
    @(negedge clk_i); eoc_i = 1'b0;
    chk(!busy_o && !done_o, "R1 stray eoc ignored", busy_o, 0);
    run_case(4, 0, "R1 result after stray eoc", 0);
    // R5 divide by 6
    smp[0] = 1000; smp[1] = 1001; smp[2] = 1002; smp[3] = 1003; smp[4] = 1004; smp[5] = 1009;
    run_case(6, 0, "R5 mean of 6", 0);
    // R2 full scale, N=8
    for (int i = 0; i < 8; i++) smp[i] = 12'hFFF;
    run_case(8, 0, "R2 full scale no overflow", 0);
    // R4 trimmed 8 drop 4
    smp[0] = 50; smp[1] = 3000; smp[2] = 10; smp[3] = 2000;
    smp[4] = 2011; smp[5] = 2023; smp[6] = 4000; smp[7] = 2030;
    run_case(8, 4, "R4 trim 8 drop 4", 0);
    // R4 descending input
    for (int i = 0; i < 8; i++) smp[i] = 12'(4000 - i * 333);
    run_case(8, 4, "R4 descending input", 0);
    // R4 6 drop 2
    smp[0] = 900; smp[1] = 5; smp[2] = 911; smp[3] = 4090; smp[4] = 920; smp[5] = 933;
    run_case(6, 2, "R4 trim 6 drop 2", 0);
    // R5 trimmed with divisor 6
    smp[0] = 70; smp[1] = 4095; smp[2] = 1500; smp[3] = 1507;
    smp[4] = 1; smp[5] = 1520; smp[6] = 1503; smp[7] = 1531;
    run_case(8, 2, "R5 trim 8 drop 2 divisor 6", 0);
    // R3 minimum burst
    smp[0] = 7; smp[1] = 8;
    run_case(2, 0, "R3 mean of 2 truncated", 0);
    // R8 start while busy ignored
    smp[0] = 10; smp[1] = 4000; smp[2] = 20; smp[3] = 3000;
    smp[4] = 33; smp[5] = 44;
    run_case(6, 0, "R8 start while busy ignored", 1);
    // R6 invalid configurations
    run_bad(0, 0);
    run_bad(9, 0);
    run_bad(5, 2);
    run_bad(4, 4);
    run_bad(6, 1);
    // R8 next valid start clears error
    smp[0] = 1; smp[1] = 2; smp[2] = 3; smp[3] = 4;
    run_case(4, 2, "R4 trim 4 drop 2 after error", 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule